// File: doc/BRIEF.md
# Bipolar Stepper Phase Translator

This block turns a pulse-train motion command into drive states for the two coils of a bipolar stepper motor. Each falling edge of the step input moves a 3-bit excitation index by one position. The direction input chooses whether that move is forward or backward, and the mode input chooses between half-step and full-step motion. The index is decoded into four bridge legs: A1 and A2 for coil A, and B1 and B2 for coil B. Each leg is either driven high, driven low, or released.

The block has three hold-off controls: an active-low phase clear, an active-high drive enable, and a thermal-fault flag. All six control inputs are asynchronous to the system clock. Each one passes through a two-flop synchroniser before it is used. No data stream flows through this block, so it has no valid/ready handshake. Every pin is a plain level signal.

A single half-step index serves both modes. Full step moves the index by two, and full-step positions 0 to 3 are the even half-step indices 0, 2, 4 and 6. Changing from full step to half step never loses position. Changing from half step to full step while the index is odd keeps the index odd, so the motor then runs through single-coil positions. Such a change should be made while the phase clear is held low.

Top module: `step_phase_xlat`

## Requirements
- R1: A falling edge on `step_i` changes the index by exactly one move. A rising edge changes nothing. The new index appears on the legs within four clock cycles of the edge.
- R2: With `dir_i` high, a move adds to the index. With `dir_i` low, a move subtracts from it. Both wrap modulo 8.
- R3: With `full_i` low, a move is 1 position. With `full_i` high, a move is 2 positions, so an odd index stays odd in full mode.
- R4: Leg bits are ordered [3]=A1, [2]=A2, [1]=B1, [0]=B2. In `legs_oe_o`, a 1 means the leg is driven. In `legs_lvl_o`, a 1 means the leg is driven high; a released leg reads 0. The odd indices decode as follows: index 1 gives A released, B1 L, B2 H; index 3 gives A1 H, A2 L, B released; index 5 gives A released, B1 H, B2 L; index 7 gives A1 L, A2 H, B released.
- R5: The even indices drive all four legs, in the order A1,A2,B1,B2: index 0 = L,H,L,H; index 2 = H,L,L,H; index 4 = H,L,H,L; index 6 = L,H,H,L.
- R6: While `phase_clr_n_i` is low, the index is forced to 0 and step edges are ignored.
- R7: While `drive_en_i` is low, all legs are released and step edges are ignored. The index is kept, and it reappears on the legs when the drive is enabled again.
- R8: While `therm_fault_i` is high, `therm_alarm_n_o` is low, all legs are released, and step edges are ignored. The index is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; the index starts at 0 |
| step_i | input | 1 | Step pulse; acts on its falling edge and idles high |
| dir_i | input | 1 | 1 = forward, 0 = reverse |
| full_i | input | 1 | 1 = full step, 0 = half step |
| phase_clr_n_i | input | 1 | Active-low phase clear |
| drive_en_i | input | 1 | 1 = legs driven, 0 = all legs released |
| therm_fault_i | input | 1 | Thermal shutdown active |
| legs_oe_o | output | 4 | Per-leg drive enable {A1,A2,B1,B2} |
| legs_lvl_o | output | 4 | Per-leg drive level {A1,A2,B1,B2} |
| therm_alarm_n_o | output | 1 | Active-low thermal alarm |

## Verification
The hardest state to reach is full-step operation from an odd index. The only path to it is to step in half mode onto an odd position and then switch to full mode without clearing the phase. The bench does exactly this and then walks through every single-coil position in both directions. It also holds the drive disabled or the fault high while it sends steps, then releases the hold and checks that the same index is decoded. This is the only way the kept phase can be seen at the ports.

// File: rtl/step_xlat_pkg.sv
package step_xlat_pkg;
  localparam int IDX_W  = 3;
  localparam int LEGS   = 4;
  // positions of the synchronised control bits
  localparam int S_STEP = 0;
  localparam int S_DIR  = 1;
  localparam int S_FULL = 2;
  localparam int S_CLRN = 3;
  localparam int S_EN   = 4;
  localparam int S_FLT  = 5;
  localparam int NCTL   = 6;

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic [LEGS-1:0] oe;
    logic [LEGS-1:0] lvl;
  } legs_t;
endpackage

// File: rtl/sx_sync.sv
module sx_sync #(
  parameter int W = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else if (s == 0) pipe[s] <= d;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sx_seq.sv
module sx_seq
  import step_xlat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_s,
  input  logic dir_s,
  input  logic full_s,
  input  logic clr_n_s,
  input  logic run_s,
  output idx_t idx_q
);
  localparam idx_t INC_HALF = idx_t'(1);
  localparam idx_t INC_FULL = idx_t'(2);

  logic step_prev;
  logic fall, adv;
  idx_t inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_prev <= 1'b1;
    else step_prev <= step_s;
  end

  assign fall = step_prev & ~step_s;
  assign adv  = fall & run_s & clr_n_s;
  assign inc  = full_s ? INC_FULL : INC_HALF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (!clr_n_s) idx_q <= '0;
    else if (adv) idx_q <= dir_s ? idx_q + inc : idx_q - inc;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_s |=> idx_q == '0); // R6
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n_s && !(fall && run_s)) |=> $stable(idx_q)); // R7
  AST_FULL_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && full_s) |=> idx_q[0] == $past(idx_q[0])); // R3
  AST_HALF_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !full_s) |=> idx_q[0] != $past(idx_q[0])); // R1
endmodule

// File: rtl/sx_decode.sv
module sx_decode
  import step_xlat_pkg::*;
(
  input  idx_t  idx,
  input  logic  drive,
  output legs_t legs
);
  legs_t raw;

  always_comb begin
    unique case (idx)
      3'd0: raw = '{oe: 4'b1111, lvl: 4'b0101};
      3'd1: raw = '{oe: 4'b0011, lvl: 4'b0001};
      3'd2: raw = '{oe: 4'b1111, lvl: 4'b1001};
      3'd3: raw = '{oe: 4'b1100, lvl: 4'b1000};
      3'd4: raw = '{oe: 4'b1111, lvl: 4'b1010};
      3'd5: raw = '{oe: 4'b0011, lvl: 4'b0010};
      3'd6: raw = '{oe: 4'b1111, lvl: 4'b0110};
      default: raw = '{oe: 4'b1100, lvl: 4'b0100};
    endcase
    legs = drive ? raw : '{oe: '0, lvl: '0};
  end

  always_comb begin
    AST_COIL_PAIRED: assert (legs.oe[3] == legs.oe[2] && legs.oe[1] == legs.oe[0]); // R4
    AST_LEGS_OPPOSE: assert (!legs.oe[3] || (legs.lvl[3] != legs.lvl[2])); // R5
    AST_ONE_COIL_ON: assert (!drive || legs.oe != 4'b0000); // R4
  end
endmodule

// File: rtl/step_phase_xlat.sv
module step_phase_xlat
  import step_xlat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic       dir_i,
  input  logic       full_i,
  input  logic       phase_clr_n_i,
  input  logic       drive_en_i,
  input  logic       therm_fault_i,
  output logic [3:0] legs_oe_o,
  output logic [3:0] legs_lvl_o,
  output logic       therm_alarm_n_o
);
  localparam logic [NCTL-1:0] CTL_RST = NCTL'(1) << S_STEP;

  logic [NCTL-1:0] ctl_raw, ctl_s;
  logic  run_s;
  idx_t  idx;
  legs_t legs;

  always_comb begin
    ctl_raw         = '0;
    ctl_raw[S_STEP] = step_i;
    ctl_raw[S_DIR]  = dir_i;
    ctl_raw[S_FULL] = full_i;
    ctl_raw[S_CLRN] = phase_clr_n_i;
    ctl_raw[S_EN]   = drive_en_i;
    ctl_raw[S_FLT]  = therm_fault_i;
  end

  sx_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  assign run_s = ctl_s[S_EN] & ~ctl_s[S_FLT];

  sx_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .step_s(ctl_s[S_STEP]), .dir_s(ctl_s[S_DIR]), .full_s(ctl_s[S_FULL]),
    .clr_n_s(ctl_s[S_CLRN]), .run_s(run_s), .idx_q(idx)
  );

  sx_decode u_dec (.idx(idx), .drive(run_s), .legs(legs));

  assign legs_oe_o       = legs.oe;
  assign legs_lvl_o      = legs.lvl;
  assign therm_alarm_n_o = ~ctl_s[S_FLT];

  AST_FAULT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !therm_alarm_n_o |-> legs_oe_o == 4'b0000); // R8
  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_s[S_EN] |-> legs_oe_o == 4'b0000); // R7
endmodule

// File: tb/tb_step_phase_xlat.sv
module tb_step_phase_xlat;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 1'b1, dir_i = 1'b1, full_i = 1'b0;
  logic phase_clr_n_i = 1'b0, drive_en_i = 1'b0, therm_fault_i = 1'b0;
  logic [3:0] legs_oe_o, legs_lvl_o;
  logic therm_alarm_n_o;

  int checks = 0, fails = 0;
  int model = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_phase_xlat dut (.*);

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req);
    logic az, bz, a1h, b1h;
    logic [3:0] eoe, elvl;
    logic ealarm;
    az  = (model % 4) == 1;
    bz  = (model % 4) == 3;
    a1h = ((model + 6) % 8) < 3;
    b1h = ((model + 4) % 8) < 3;
    if (drive_en_i && !therm_fault_i) begin
      eoe  = {~az, ~az, ~bz, ~bz};
      elvl = {a1h & ~az, ~a1h & ~az, b1h & ~bz, ~b1h & ~bz};
    end else begin
      eoe = 4'b0; elvl = 4'b0;
    end
    ealarm = ~therm_fault_i;
    checks++;
    if (legs_oe_o !== eoe || legs_lvl_o !== elvl || therm_alarm_n_o !== ealarm) begin
      fails++;
      $display("FAIL %s idx=%0d: oe=%b lvl=%b alarm=%b expected oe=%b lvl=%b alarm=%b",
               req, model, legs_oe_o, legs_lvl_o, therm_alarm_n_o, eoe, elvl, ealarm);
    end
  endtask

  // full step pulse: checks after the falling edge and again after the rising edge
  task automatic pulse(input string req);
    int inc;
    step_i = 1'b0;
    wait_cyc(5);
    if (phase_clr_n_i && drive_en_i && !therm_fault_i) begin
      inc = full_i ? 2 : 1;
      model = (model + (dir_i ? inc : 8 - inc)) % 8;
    end
    if (!phase_clr_n_i) model = 0;
    check(req);
    step_i = 1'b1;
    wait_cyc(5);
    check("R1 rising edge");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R7 reset state disabled");
    drive_en_i = 1'b1;
    wait_cyc(4);
    check("R6 reset state index 0");
    phase_clr_n_i = 1'b1;
    wait_cyc(4);

    // half step forward and backward over two turns
    dir_i = 1'b1;
    for (int i = 0; i < 16; i++) pulse("R4 half forward R2");
    dir_i = 1'b0;
    for (int i = 0; i < 16; i++) pulse("R4 half reverse R2");

    // full step from an even index
    full_i = 1'b1; wait_cyc(4);
    dir_i = 1'b1;
    for (int i = 0; i < 8; i++) pulse("R5 full forward R3");
    dir_i = 1'b0;
    for (int i = 0; i < 3; i++) pulse("R5 full reverse R2");

    // full to half keeps position
    full_i = 1'b0; wait_cyc(4);
    dir_i = 1'b1;
    pulse("R3 full to half");
    // half to full from odd: stays on single-coil positions
    full_i = 1'b1; wait_cyc(4);
    for (int i = 0; i < 6; i++) pulse("R3 full from odd forward");
    dir_i = 1'b0;
    for (int i = 0; i < 6; i++) pulse("R3 full from odd reverse");

    // disable holds index
    full_i = 1'b0; wait_cyc(4);
    drive_en_i = 1'b0; wait_cyc(4);
    check("R7 released");
    for (int i = 0; i < 3; i++) pulse("R7 steps ignored");
    drive_en_i = 1'b1; wait_cyc(4);
    check("R7 index kept");

    // thermal fault holds index
    therm_fault_i = 1'b1; wait_cyc(4);
    check("R8 alarm and release");
    for (int i = 0; i < 3; i++) pulse("R8 steps ignored");
    therm_fault_i = 1'b0; wait_cyc(4);
    check("R8 index kept");

    // phase clear
    dir_i = 1'b1;
    pulse("R1 before clear");
    phase_clr_n_i = 1'b0; wait_cyc(4);
    model = 0;
    check("R6 cleared");
    pulse("R6 steps ignored");
    phase_clr_n_i = 1'b1; wait_cyc(4);
    pulse("R6 resume from 0");

    done = 1;
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end
endmodule